// File: doc/BRIEF.md
# Operate Command Qualifier with Sector Capture

This block sits in a disk drive's control logic and handles the read/write "operate" command. When the controller presents the operate tag, the block checks the drive's status latches and the bus-out byte. If the command can run, it turns the byte into single-cycle operation strobes: address-mark write, address-mark search, data enable, head select, head advance, write, read and sector save. If it cannot run, the block pulses a command reject. It also derives read select and data enable. After an address-mark write it holds a window that masks write-fault detection.

The sector-save operation copies a free-running sector count into a sector register that the controller can read back. The timing of the copy depends on a clock-position counter. Early in the sector clock cycle the copy happens at once. Late in the cycle it waits for a fixed early position of the next cycle. A reset-interrupt input clears the register.

Top module: `opcmd_qualifier`

## Requirements
- R1: An operate command (`tag11_dec` high at a clock edge) is accepted only when all of these hold: `cmd_valid` high, `on_cyl` high, and `dev_check`, `diag1` and `sel_lock` all low. No bus-out parity takes part in the check.
- R2: An operate command that is not accepted makes `cmd_reject` high for exactly the cycle after the edge, with `op_strb` zero. An accepted command gives no reject.
- R3: `bus_out[i]` carries operate bit i, with these meanings: 0 address-mark write, 1 address-mark search, 2 data enable, 3 head select, 4 head advance, 5 write, 6 read, 7 sector save. The accepted values are 8'h29, 8'h4E, 8'h28, 8'h4C, 8'h10 and 8'h80.
- R4: Any other `bus_out` value on an operate command is rejected and produces no strobe.
- R5: An accepted command copies `bus_out` onto `op_strb` for the one cycle after the edge.
- R6: `rd_sel` pulses in the cycle after an accepted command with bit 6 set, but only if `write_gate` is low and `head_sel` is high at that edge.
- R7: `data_en` pulses only together with `rd_sel`, and only when bit 2 is also set.
- R8: An accepted head advance (bit 4) while `end_of_cyl` is high suppresses `op_strb[4]` and pulses `hadv_check` instead.
- R9: An accepted command with bit 0 set holds `wf_blank` high for exactly BLANK_CYC cycles, starting the cycle after the edge. A new command of this kind restarts the window.
- R10: An accepted sector save with `clk_pos` below SAVE_LIMIT loads `sec_cnt` into the sector register at that edge.
- R11: An accepted sector save with `clk_pos` at or above SAVE_LIMIT leaves the register unchanged. It loads `sec_cnt` at the first later edge where `clk_pos` equals LATE_POS, and only once.
- R12: `sect_bi` presents the register with bit 0 as the high-side bit (`sec_cnt[7]`) and bits 1 to 7 carrying weights 64 down to 1 (`sect_bi[k] = sec_cnt[7-k]`).
- R13: `rst_intr` clears the sector register at the next edge and cancels a pending deferred load.
- R14: While `rst_n` is low, all strobes, `cmd_reject`, `hadv_check`, `wf_blank` and `sect_bi` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tag11_dec | input | 1 | Operate tag decoded |
| cmd_valid | input | 1 | Command valid from tag logic |
| bus_out | input | 8 | Operate bits, bit i = operate bit i |
| dev_check | input | 1 | Device check latch |
| diag1 | input | 1 | Diagnostic mode 1 latch |
| sel_lock | input | 1 | Select lock latch |
| on_cyl | input | 1 | Heads on cylinder |
| write_gate | input | 1 | Write gate active |
| head_sel | input | 1 | A head is selected |
| end_of_cyl | input | 1 | Last head of cylinder selected |
| sec_cnt | input | 8 | Running sector count, bit 7 high side |
| clk_pos | input | CLK_W | Clock position within the sector |
| rst_intr | input | 1 | Reset interrupt, clears sector register |
| op_strb | output | 8 | Operation strobes, bit per operate bit |
| rd_sel | output | 1 | Read select pulse |
| data_en | output | 1 | Read data enable pulse |
| cmd_reject | output | 1 | Command reject pulse |
| hadv_check | output | 1 | Head advance past end of cylinder |
| wf_blank | output | 1 | Write-fault blanking window |
| sect_bi | output | 8 | Sector register in bus-in order |

## Verification
Strobes, `rd_sel`, `data_en`, `cmd_reject` and `hadv_check` are due one edge after the operate tag. Immediate sector loads and `rst_intr` also show on `sect_bi` one edge later. A deferred load shows one edge after the edge at which `clk_pos` equals LATE_POS. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge, so every result is read in the cycle it is due. It then clears the tag before the following edge. The blanking window is measured by counting the sampled cycles with `wf_blank` high until it drops.

// File: rtl/opcmd_qualifier.sv
module opcmd_qualifier #(
  parameter int CLK_W      = 6,
  parameter int SAVE_LIMIT = 50,
  parameter int LATE_POS   = 4,
  parameter int BLANK_CYC  = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tag11_dec,
  input  logic             cmd_valid,
  input  logic [7:0]       bus_out,
  input  logic             dev_check,
  input  logic             diag1,
  input  logic             sel_lock,
  input  logic             on_cyl,
  input  logic             write_gate,
  input  logic             head_sel,
  input  logic             end_of_cyl,
  input  logic [7:0]       sec_cnt,
  input  logic [CLK_W-1:0] clk_pos,
  input  logic             rst_intr,
  output logic [7:0]       op_strb,
  output logic             rd_sel,
  output logic             data_en,
  output logic             cmd_reject,
  output logic             hadv_check,
  output logic             wf_blank,
  output logic [7:0]       sect_bi
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam logic [BW-1:0]    BLOAD = BW'(BLANK_CYC);
  localparam logic [CLK_W-1:0] LIM   = CLK_W'(SAVE_LIMIT);
  localparam logic [CLK_W-1:0] LATE  = CLK_W'(LATE_POS);

  logic          pat_ok, tag_ok, accept, rd_ok, pending;
  logic [BW-1:0] bcnt;
  logic [7:0]    sec_reg;

  always_comb begin
    case (bus_out)
      8'h29, 8'h4E, 8'h28, 8'h4C, 8'h10, 8'h80: pat_ok = 1'b1;
      default:                                 pat_ok = 1'b0;
    endcase
  end

  assign tag_ok = tag11_dec & cmd_valid & ~dev_check & ~diag1 & ~sel_lock & on_cyl;
  assign accept = tag_ok & pat_ok;
  assign rd_ok  = accept & bus_out[6] & ~write_gate & head_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_strb    <= '0;
      rd_sel     <= 1'b0;
      data_en    <= 1'b0;
      cmd_reject <= 1'b0;
      hadv_check <= 1'b0;
    end else begin
      op_strb    <= accept ? (bus_out & ~{3'b000, end_of_cyl, 4'b0000}) : 8'h00;
      rd_sel     <= rd_ok;
      data_en    <= rd_ok & bus_out[2];
      cmd_reject <= tag11_dec & ~accept;
      hadv_check <= accept & bus_out[4] & end_of_cyl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    bcnt <= '0;
    else if (accept & bus_out[0])  bcnt <= BLOAD;
    else if (bcnt != '0)           bcnt <= bcnt - BW'(1);
  end
  assign wf_blank = (bcnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_reg <= '0;
      pending <= 1'b0;
    end else if (rst_intr) begin
      sec_reg <= '0;
      pending <= 1'b0;
    end else if (accept & bus_out[7] & (clk_pos < LIM)) begin
      sec_reg <= sec_cnt;
      pending <= 1'b0;
    end else if (accept & bus_out[7]) begin
      pending <= 1'b1;
    end else if (pending && clk_pos == LATE) begin
      sec_reg <= sec_cnt;
      pending <= 1'b0;
    end
  end

  always_comb
    for (int k = 0; k < 8; k++) sect_bi[k] = sec_reg[7-k];

  assert_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tag11_dec && (!cmd_valid || dev_check || diag1 || sel_lock || !on_cyl))
      |=> (cmd_reject && op_strb == 8'h00));
  assert_unlisted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tag11_dec && !pat_ok) |=> (cmd_reject && op_strb == 8'h00));
  assert_strobe_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_strb != 8'h00) |-> $past(tag11_dec));
  assert_readsel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |-> $past(head_sel && !write_gate));
  assert_dataen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_en |-> rd_sel);
  assert_hadv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hadv_check |-> !op_strb[4]);
  assert_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_ok && bus_out == 8'h29) |=> wf_blank);
  assert_late_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && clk_pos == LATE && !rst_intr && !(accept && bus_out[7]))
      |=> (sec_reg == $past(sec_cnt)));
  assert_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rst_intr |=> (sect_bi == 8'h00));
endmodule

// File: tb/sim_opcmd_qualifier.sv
`timescale 1ns/1ps
module sim_opcmd_qualifier;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tag11_dec = 0, cmd_valid = 1, dev_check = 0, diag1 = 0, sel_lock = 0, on_cyl = 1;
  logic write_gate = 0, head_sel = 1, end_of_cyl = 0, rst_intr = 0;
  logic [7:0] bus_out = 0, sec_cnt = 0;
  logic [5:0] clk_pos = 0;
  logic [7:0] op_strb, sect_bi;
  logic rd_sel, data_en, cmd_reject, hadv_check, wf_blank;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;

  opcmd_qualifier u0 (.clk(clk), .rst_n(rst_n), .tag11_dec(tag11_dec), .cmd_valid(cmd_valid),
    .bus_out(bus_out), .dev_check(dev_check), .diag1(diag1), .sel_lock(sel_lock),
    .on_cyl(on_cyl), .write_gate(write_gate), .head_sel(head_sel), .end_of_cyl(end_of_cyl),
    .sec_cnt(sec_cnt), .clk_pos(clk_pos), .rst_intr(rst_intr), .op_strb(op_strb),
    .rd_sel(rd_sel), .data_en(data_en), .cmd_reject(cmd_reject), .hadv_check(hadv_check),
    .wf_blank(wf_blank), .sect_bi(sect_bi));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev(input logic [7:0] v);
    for (int k = 0; k < 8; k++) rev[k] = v[7-k];
  endfunction

  function automatic logic listed(input logic [7:0] v);
    return v == 8'h29 || v == 8'h4E || v == 8'h28 || v == 8'h4C || v == 8'h10 || v == 8'h80;
  endfunction

  task automatic issue(input logic [7:0] bo);
    @(negedge clk); tag11_dec = 1; bus_out = bo;
    @(posedge clk); #1;
  endtask

  task automatic step;
    @(negedge clk); tag11_dec = 0; rst_intr = 0;
    @(posedge clk); #1;
  endtask

  task automatic rejected(input string req);
    issue(8'h4C);
    chk(req, cmd_reject, 1); chk(req, op_strb, 0);
    step;
  endtask

  initial begin
    #2_000_000;
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R14 strb", op_strb, 0); chk("R14 rej", cmd_reject, 0);
    chk("R14 blank", wf_blank, 0); chk("R14 sect", sect_bi, 0);
    chk("R14 hadv", hadv_check, 0);
    @(negedge clk); rst_n = 1;

    for (int v = 0; v < 256; v++) begin
      logic acc;
      acc = listed(8'(v));
      issue(8'(v));
      chk("R3 R5 strb", op_strb, acc ? v : 0);
      chk("R2 R4 rej", cmd_reject, !acc);
      chk("R6 rdsel", rd_sel, acc & v[6]);
      chk("R7 dataen", data_en, acc & v[6] & v[2]);
      step;
      chk("R5 one cycle", op_strb, 0);
    end

    issue(8'h4C); chk("R1 accept", cmd_reject, 0); chk("R1 strb", op_strb, 8'h4C); step;
    cmd_valid = 0;  rejected("R1 cmd_valid"); cmd_valid = 1;
    on_cyl = 0;     rejected("R1 on_cyl");    on_cyl = 1;
    dev_check = 1;  rejected("R1 dev_check"); dev_check = 0;
    diag1 = 1;      rejected("R1 diag1");     diag1 = 0;
    sel_lock = 1;   rejected("R1 sel_lock");  sel_lock = 0;

    write_gate = 1; issue(8'h4C);
    chk("R6 wg strb", op_strb, 8'h4C); chk("R6 wg rdsel", rd_sel, 0); chk("R7 wg", data_en, 0);
    step; write_gate = 0;
    head_sel = 0; issue(8'h4E);
    chk("R6 nohead", rd_sel, 0); chk("R7 nohead", data_en, 0); step; head_sel = 1;

    end_of_cyl = 1; issue(8'h10);
    chk("R8 strb", op_strb, 0); chk("R8 hadv", hadv_check, 1); chk("R8 rej", cmd_reject, 0);
    step; end_of_cyl = 0;
    issue(8'h10); chk("R8 normal", op_strb, 8'h10); chk("R8 nohadv", hadv_check, 0); step;

    repeat (520) step;
    chk("R9 idle", wf_blank, 0);
    begin
      int n;
      issue(8'h29); n = wf_blank ? 1 : 0;
      @(negedge clk); tag11_dec = 0;
      while (wf_blank && n < 2000) begin @(posedge clk); #1; if (wf_blank) n++; end
      chk("R9 window", n, 500);
    end
    issue(8'h29); step; repeat (300) step;
    issue(8'h29); step; repeat (400) step;
    chk("R9 retrigger", wf_blank, 1);
    repeat (120) step;
    chk("R9 end", wf_blank, 0);

    clk_pos = 49; sec_cnt = 8'hA5; issue(8'h80);
    chk("R10 immediate", sect_bi, rev(8'hA5)); step;
    sec_cnt = 8'h80; clk_pos = 0; issue(8'h80);
    chk("R12 high side", sect_bi, 8'h01); step;
    sec_cnt = 8'h01; issue(8'h80);
    chk("R12 weight1", sect_bi, 8'h80); step;
    sec_cnt = 8'hA5; issue(8'h80); step;

    clk_pos = 50; sec_cnt = 8'h3C; issue(8'h80);
    chk("R11 deferred", sect_bi, rev(8'hA5));
    clk_pos = 20; sec_cnt = 8'h11; step;
    chk("R11 waiting", sect_bi, rev(8'hA5));
    clk_pos = 4; sec_cnt = 8'h5A; step;
    chk("R11 late load", sect_bi, rev(8'h5A));
    clk_pos = 4; sec_cnt = 8'h77; step;
    chk("R11 once", sect_bi, rev(8'h5A));

    @(negedge clk); rst_intr = 1; @(posedge clk); #1;
    chk("R13 clear", sect_bi, 0);
    clk_pos = 60; sec_cnt = 8'hC3; step; issue(8'h80); step;
    @(negedge clk); rst_intr = 1; @(posedge clk); #1;
    clk_pos = 4; step;
    chk("R13 cancel", sect_bi, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule